// File: doc/BRIEF.md
# Phase-Change Memory Write Controller

This block controls the write path in front of a phase-change memory array. The array is slow and wears out with use, and it programs cleared bits and set bits at different speeds. The host issues one of three operations on a block: read, write, or pre-set to all ones. On a write, the block first reads the stored word. It then programs only the bits that change. Bits going to zero are driven on one programming strobe and bits going to one on a second strobe, and each strobe has its own latency. Once a block has been pre-set, a later write skips the first read and only clears bits.

Programming is the only step that can go wrong. Every programming pass is therefore followed by a verify read. On the first mismatch the block re-runs the whole sequence once by itself. A second mismatch is reported to the host: it sets a sticky error flag and records the failing block address. The block keeps a write counter for each block and raises a sticky wear alert when a counter reaches a limit that the host programs.

The array side is a simple behavioural port. It has an address, a read enable with data back, and two programming strobes, each with its own bit mask.

Top module: `pcm_wr_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1. `resp_valid`, `arr_rd_en`, `arr_set_en`, `arr_rst_en`, `err_flag` and `wear_alert` are all 0.
- R2: A read (`req_op` 2'b00; code 2'b11 also reads) holds `arr_rd_en` for RD_LAT cycles. It then returns the stored word on `resp_rdata` with a one-cycle `resp_valid`. It issues no programming strobe and leaves the block's write count unchanged.
- R3: A write (`req_op` 2'b01) to a block that is not pre-set reads the stored word S and writes the new data N. The set mask is N & ~S and the reset mask is S & ~N. After the write the array holds N, and `resp_rdata` returns the word read back.
- R4: The zero phase always comes before the one phase. `arr_rst_en` is held for exactly ZERO_LAT cycles and `arr_set_en` for exactly ONE_LAT cycles, and the two strobes are never high together.
- R5: A phase whose mask is empty is skipped. If both masks are empty, the write issues no strobe and no verify read, uses RD_LAT read cycles in total, and leaves the count unchanged.
- R6: A pre-set (`req_op` 2'b10) sets to one every stored bit that is 0 and marks the block as pre-set. The next write to that block skips the first read: it issues only `arr_rst_en` with mask ~N, and RD_LAT read cycles in total (the verify).
- R7: Every programming pass is followed by RD_LAT cycles of `arr_rd_en` for the verify, and reads never overlap a strobe. On the first verify mismatch the block re-reads and reprograms once. If that retry verifies, `resp_err` is 0.
- R8: A second verify mismatch gives `resp_err` = 1, sets `err_flag`, and loads the block into `err_addr`. `err_flag` stays set until `status_clr` is pulsed.
- R9: A block's write count rises by one for every programming pass that changes at least one bit. `resp_wcount` returns the count after the operation.
- R10: `wear_alert` is set when an increment brings a count to a value of at least `wear_limit`. It stays set until `status_clr` is pulsed.
- R11: A write count that has reached its all-ones value stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_op | input | 2 | 00 read, 01 write, 10 pre-set, 11 read |
| req_addr | input | AW | Block address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DW | Word read (read) or read back (write, pre-set) |
| resp_err | output | 1 | Operation ended in a write error |
| resp_wcount | output | CW | Write count of the block |
| wear_limit | input | CW | Wear alert threshold |
| wear_alert | output | 1 | Sticky wear alert |
| err_flag | output | 1 | Sticky write error |
| err_addr | output | AW | Block of the last write error |
| status_clr | input | 1 | Clears `err_flag` and `wear_alert` |
| arr_addr | output | AW | Array block address |
| arr_rd_en | output | 1 | Array read enable |
| arr_rdata | input | DW | Array read data |
| arr_set_en | output | 1 | Program-to-one strobe |
| arr_set_mask | output | DW | Bits to set |
| arr_rst_en | output | 1 | Program-to-zero strobe |
| arr_rst_mask | output | DW | Bits to clear |

## Verification
The bench builds the controller with a 16-bit word, eight blocks and a 4-bit write counter. The default latencies of 2, 10 and 20 cycles are kept, so strobe lengths can be counted exactly. The narrow counter lets a short run reach both the wear limit and counter saturation. The bench's array model can drop one programming pass or hold a bit stuck at zero. This brings both the silent single retry and the reported double failure within reach.

// File: rtl/pcm_wr_pkg.sv
// Shared types for the phase-change memory write controller.
// Assumes: nothing beyond the encodings declared here.
package pcm_wr_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_PRESET = 2'b10,
        OP_READ2  = 2'b11
    } pcm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CMP,
        ST_ZERO,
        ST_ONE,
        ST_VERIFY,
        ST_DONE
    } pcm_state_e;

endpackage

// File: rtl/pcm_phase_timer.sv
// Counts cycles spent in the current controller state.
// Assumes: restart is high on the cycle before a new state begins;
// last is high on the final cycle of a phase of length lat (lat >= 1).
module pcm_phase_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] lat,
    output logic          last
);
    logic [TW-1:0] cnt_q;

    // Cycle counter, cleared at every state change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else                   cnt_q <= cnt_q + TW'(1);
    end

    // Final cycle of the phase.
    assign last = (cnt_q == lat - TW'(1));
endmodule

// File: rtl/pcm_bit_diff.sv
// Splits a word update into a set mask and a reset mask.
// Assumes: when assume_ones is high, the stored word is treated as all ones
// (block already pre-set), so no bit can need setting.
module pcm_bit_diff #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] stored,
    input  logic [DW-1:0] target,
    input  logic          assume_ones,
    output logic [DW-1:0] set_mask,
    output logic [DW-1:0] rst_mask
);
    logic [DW-1:0] base;

    // Pick the baseline the target is compared against.
    always_comb begin
        base     = assume_ones ? '1 : stored;
        set_mask = target & ~base;
        rst_mask = base & ~target;
    end
endmodule

// File: rtl/pcm_wear_table.sv
// Per-block saturating write counters with a sticky wear alert.
// Assumes: at most one increment per cycle; the alert set takes priority
// over a clear in the same cycle.
module pcm_wear_table #(
    parameter int AW = 4,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic [AW-1:0] inc_addr,
    input  logic [AW-1:0] rd_addr,
    input  logic [CW-1:0] limit,
    input  logic          clr,
    output logic [CW-1:0] rd_count,
    output logic          alert
);
    localparam int NBLK = 1 << AW;

    logic [CW-1:0] cnt_q [NBLK];
    logic [CW-1:0] cur_cnt;
    logic [CW-1:0] nxt_cnt;

    // Next value of the addressed counter, held at all ones.
    always_comb begin
        cur_cnt = cnt_q[inc_addr];
        nxt_cnt = (cur_cnt == '1) ? cur_cnt : cur_cnt + CW'(1);
    end

    // Counter storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) cnt_q[i] <= '0;
        end else if (inc) begin
            cnt_q[inc_addr] <= nxt_cnt;
        end
    end

    // Sticky alert when a counter reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        alert <= 1'b0;
        else if (inc && nxt_cnt >= limit)  alert <= 1'b1;
        else if (clr)                      alert <= 1'b0;
    end

    assign rd_count = cnt_q[rd_addr];
endmodule

// File: rtl/pcm_wr_ctrl.sv
// Write-path controller for a phase-change memory array.
// Runs read, then compare, then the zero phase, the one phase and a verify,
// skipping any step that has nothing to do. Retries once on a verify
// mismatch and counts programming passes per block.
// Assumes: arr_rdata is valid while arr_rd_en is high and is sampled on the
// last read cycle; the array applies each mask while its strobe is high.
module pcm_wr_ctrl
    import pcm_wr_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 4,
    parameter int CW       = 24,
    parameter int RD_LAT   = 2,
    parameter int ZERO_LAT = 10,
    parameter int ONE_LAT  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          resp_valid,
    output logic [DW-1:0] resp_rdata,
    output logic          resp_err,
    output logic [CW-1:0] resp_wcount,
    input  logic [CW-1:0] wear_limit,
    output logic          wear_alert,
    output logic          err_flag,
    output logic [AW-1:0] err_addr,
    input  logic          status_clr,
    output logic [AW-1:0] arr_addr,
    output logic          arr_rd_en,
    input  logic [DW-1:0] arr_rdata,
    output logic          arr_set_en,
    output logic [DW-1:0] arr_set_mask,
    output logic          arr_rst_en,
    output logic [DW-1:0] arr_rst_mask
);
    localparam int NBLK    = 1 << AW;
    localparam int MAX_LAT = (ONE_LAT > ZERO_LAT)
                           ? ((ONE_LAT > RD_LAT) ? ONE_LAT : RD_LAT)
                           : ((ZERO_LAT > RD_LAT) ? ZERO_LAT : RD_LAT);
    localparam int TW      = $clog2(MAX_LAT + 1) + 1;

    pcm_state_e    state_q, state_d;
    pcm_op_e       op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] stored_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] set_m_q, rst_m_q;
    logic [DW-1:0] set_m_c, rst_m_c;
    logic [DW-1:0] target;
    logic          assume_q;
    logic          retry_q;
    logic          err_q;
    logic          err_flag_q;
    logic [AW-1:0] err_addr_q;
    logic [NBLK-1:0] preset_q;
    logic          is_modify;
    logic          phase_last;
    logic [TW-1:0] phase_lat;
    logic          wear_inc;
    logic          verify_ok;

    // Word the operation must leave in the array.
    always_comb begin
        is_modify = (op_q == OP_WRITE) || (op_q == OP_PRESET);
        target    = (op_q == OP_PRESET) ? '1 : wdata_q;
        verify_ok = (arr_rdata == target);
    end

    pcm_bit_diff #(.DW(DW)) u_diff (
        .stored      (stored_q),
        .target      (target),
        .assume_ones (assume_q),
        .set_mask    (set_m_c),
        .rst_mask    (rst_m_c)
    );

    // Latency of the phase the controller is in.
    always_comb begin
        case (state_q)
            ST_READ, ST_VERIFY: phase_lat = TW'(RD_LAT);
            ST_ZERO:            phase_lat = TW'(ZERO_LAT);
            ST_ONE:             phase_lat = TW'(ONE_LAT);
            default:            phase_lat = TW'(1);
        endcase
    end

    pcm_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .lat     (phase_lat),
        .last    (phase_last)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (pcm_op_e'(req_op) == OP_WRITE && preset_q[req_addr])
                        state_d = ST_CMP;
                    else
                        state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (phase_last) state_d = is_modify ? ST_CMP : ST_DONE;
            end
            ST_CMP: begin
                if (|rst_m_c)      state_d = ST_ZERO;
                else if (|set_m_c) state_d = ST_ONE;
                else               state_d = ST_DONE;
            end
            ST_ZERO: begin
                if (phase_last) state_d = (|set_m_q) ? ST_ONE : ST_VERIFY;
            end
            ST_ONE: begin
                if (phase_last) state_d = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (phase_last) state_d = (verify_ok || retry_q) ? ST_DONE : ST_READ;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, read data, masks, retry and error bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_READ;
            addr_q     <= '0;
            wdata_q    <= '0;
            stored_q   <= '0;
            rdata_q    <= '0;
            set_m_q    <= '0;
            rst_m_q    <= '0;
            assume_q   <= 1'b0;
            retry_q    <= 1'b0;
            err_q      <= 1'b0;
            err_flag_q <= 1'b0;
            err_addr_q <= '0;
            preset_q   <= '0;
        end else begin
            if (status_clr) err_flag_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q     <= pcm_op_e'(req_op);
                        addr_q   <= req_addr;
                        wdata_q  <= req_wdata;
                        retry_q  <= 1'b0;
                        err_q    <= 1'b0;
                        assume_q <= 1'b0;
                        if (pcm_op_e'(req_op) == OP_WRITE && preset_q[req_addr]) begin
                            assume_q           <= 1'b1;
                            preset_q[req_addr] <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (phase_last) begin
                        stored_q <= arr_rdata;
                        rdata_q  <= arr_rdata;
                        assume_q <= 1'b0;
                    end
                end
                ST_CMP: begin
                    set_m_q <= set_m_c;
                    rst_m_q <= rst_m_c;
                end
                ST_VERIFY: begin
                    if (phase_last) begin
                        rdata_q <= arr_rdata;
                        if (!verify_ok) begin
                            if (!retry_q) begin
                                retry_q <= 1'b1;
                            end else begin
                                err_q      <= 1'b1;
                                err_flag_q <= 1'b1;
                                err_addr_q <= addr_q;
                            end
                        end
                    end
                end
                ST_DONE: begin
                    if (op_q == OP_PRESET && !err_q) preset_q[addr_q] <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Count a pass only when it changes at least one bit.
    assign wear_inc = (state_q == ST_CMP) && ((|set_m_c) || (|rst_m_c));

    pcm_wear_table #(.AW(AW), .CW(CW)) u_wear (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (wear_inc),
        .inc_addr (addr_q),
        .rd_addr  (addr_q),
        .limit    (wear_limit),
        .clr      (status_clr),
        .rd_count (resp_wcount),
        .alert    (wear_alert)
    );

    // Port drive.
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        resp_valid   = (state_q == ST_DONE);
        resp_rdata   = rdata_q;
        resp_err     = err_q;
        err_flag     = err_flag_q;
        err_addr     = err_addr_q;
        arr_addr     = addr_q;
        arr_rd_en    = (state_q == ST_READ) || (state_q == ST_VERIFY);
        arr_rst_en   = (state_q == ST_ZERO);
        arr_set_en   = (state_q == ST_ONE);
        arr_rst_mask = arr_rst_en ? rst_m_q : '0;
        arr_set_mask = arr_set_en ? set_m_q : '0;
    end
endmodule

// File: rtl/pcm_wr_ctrl_chk.sv
// Property checker for pcm_wr_ctrl, attached by bind.
// Assumes: only port-level signals of the controller are observed.
module pcm_wr_ctrl_chk #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic resp_valid,
    input logic resp_err,
    input logic err_flag,
    input logic wear_alert,
    input logic status_clr,
    input logic arr_rd_en,
    input logic arr_set_en,
    input logic arr_rst_en
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_set_en && arr_rst_en)); // R4
    AST_ONE_NOT_BEFORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_set_en) |-> !arr_rst_en); // R4
    AST_RD_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_en |-> !(arr_set_en || arr_rst_en)); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en || arr_set_en || arr_rst_en) |-> !req_ready); // R1
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R2
    AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> err_flag); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !status_clr) |=> err_flag); // R8
    AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wear_alert && !status_clr) |=> wear_alert); // R10
endmodule

bind pcm_wr_ctrl pcm_wr_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .err_flag   (err_flag),
    .wear_alert (wear_alert),
    .status_clr (status_clr),
    .arr_rd_en  (arr_rd_en),
    .arr_set_en (arr_set_en),
    .arr_rst_en (arr_rst_en)
);

// File: tb/tb_pcm_wr_ctrl.sv
`timescale 1ns/1ps
module tb_pcm_wr_ctrl;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam int CW = 4;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, resp_err;
    logic [DW-1:0] resp_rdata;
    logic [CW-1:0] resp_wcount;
    logic [CW-1:0] wear_limit = '1;
    logic          wear_alert, err_flag;
    logic [AW-1:0] err_addr;
    logic          status_clr = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          arr_rd_en, arr_set_en, arr_rst_en;
    logic [DW-1:0] arr_rdata, arr_set_mask, arr_rst_mask;

    int checks = 0;
    int errors = 0;

    // Behavioural array with fault hooks.
    logic [DW-1:0] mem [NB];
    logic [DW-1:0] stuck0 [NB];
    logic drop_set = 1'b0;
    logic prev_set = 1'b0;

    // Per-operation monitor results.
    int rd_cyc, set_cyc, rst_cyc;
    logic [DW-1:0] set_seen, rst_seen;
    logic order_bad;
    logic [DW-1:0] r_rdata;
    logic r_err;
    logic [CW-1:0] r_cnt;

    always #2 clk = ~clk;

    assign arr_rdata = mem[arr_addr] & ~stuck0[arr_addr];

    pcm_wr_ctrl #(.DW(DW), .AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
        .resp_wcount(resp_wcount), .wear_limit(wear_limit), .wear_alert(wear_alert),
        .err_flag(err_flag), .err_addr(err_addr), .status_clr(status_clr),
        .arr_addr(arr_addr), .arr_rd_en(arr_rd_en), .arr_rdata(arr_rdata),
        .arr_set_en(arr_set_en), .arr_set_mask(arr_set_mask),
        .arr_rst_en(arr_rst_en), .arr_rst_mask(arr_rst_mask)
    );

    // Array update and strobe monitor, away from the active edge.
    always @(negedge clk) begin
        if (arr_rd_en) rd_cyc++;
        if (arr_rst_en) begin
            rst_cyc++;
            rst_seen |= arr_rst_mask;
            if (set_cyc != 0) order_bad = 1'b1;
            mem[arr_addr] = mem[arr_addr] & ~arr_rst_mask;
        end
        if (arr_set_en) begin
            set_cyc++;
            set_seen |= arr_set_mask;
            if (!drop_set) mem[arr_addr] = mem[arr_addr] | arr_set_mask;
        end
        if (prev_set && !arr_set_en) drop_set = 1'b0;
        prev_set = arr_set_en;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        rd_cyc = 0; set_cyc = 0; rst_cyc = 0;
        set_seen = '0; rst_seen = '0; order_bad = 1'b0;
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (resp_valid) begin
                r_rdata = resp_rdata; r_err = resp_err; r_cnt = resp_wcount;
                return;
            end
        end
        chk("R2", "response timeout", 32'd0, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "resp_valid", 32'(resp_valid), 32'd0);
        chk("R1", "strobes", 32'({arr_rd_en, arr_set_en, arr_rst_en}), 32'd0);
        chk("R1", "err_flag", 32'(err_flag), 32'd0);
        chk("R1", "wear_alert", 32'(wear_alert), 32'd0);
    endtask

    task automatic t_write_fresh();
        do_op(2'b01, 0, 16'hA5C3);
        chk("R3", "set mask", 32'(set_seen), 32'h0000A5C3);
        chk("R3", "rst mask", 32'(rst_seen), 32'd0);
        chk("R3", "array", 32'(mem[0]), 32'h0000A5C3);
        chk("R3", "resp_rdata", 32'(r_rdata), 32'h0000A5C3);
        chk("R4", "set cycles", 32'(set_cyc), 32'd20);
        chk("R5", "zero phase skipped", 32'(rst_cyc), 32'd0);
        chk("R7", "read cycles", 32'(rd_cyc), 32'd4);
        chk("R9", "count", 32'(r_cnt), 32'd1);
    endtask

    task automatic t_write_both();
        do_op(2'b01, 0, 16'h5AC3);
        chk("R3", "set mask", 32'(set_seen), 32'h00005A00);
        chk("R3", "rst mask", 32'(rst_seen), 32'h0000A500);
        chk("R3", "array", 32'(mem[0]), 32'h00005AC3);
        chk("R4", "rst cycles", 32'(rst_cyc), 32'd10);
        chk("R4", "set cycles", 32'(set_cyc), 32'd20);
        chk("R4", "zeros before ones", 32'(order_bad), 32'd0);
        chk("R9", "count", 32'(r_cnt), 32'd2);
    endtask

    task automatic t_write_same();
        do_op(2'b01, 0, 16'h5AC3);
        chk("R5", "strobes", 32'(set_cyc + rst_cyc), 32'd0);
        chk("R5", "read cycles", 32'(rd_cyc), 32'd2);
        chk("R5", "count unchanged", 32'(r_cnt), 32'd2);
    endtask

    task automatic t_read();
        do_op(2'b00, 0, 16'h0000);
        chk("R2", "rdata", 32'(r_rdata), 32'h00005AC3);
        chk("R2", "read cycles", 32'(rd_cyc), 32'd2);
        chk("R2", "strobes", 32'(set_cyc + rst_cyc), 32'd0);
        chk("R2", "count", 32'(r_cnt), 32'd2);
        do_op(2'b11, 0, 16'h0000);
        chk("R2", "code 11 rdata", 32'(r_rdata), 32'h00005AC3);
    endtask

    task automatic t_zero_only();
        do_op(2'b01, 0, 16'h5A03);
        chk("R5", "rst mask", 32'(rst_seen), 32'h000000C0);
        chk("R5", "one phase skipped", 32'(set_cyc), 32'd0);
        chk("R5", "rst cycles", 32'(rst_cyc), 32'd10);
        chk("R5", "array", 32'(mem[0]), 32'h00005A03);
    endtask

    task automatic t_preset();
        mem[1] = 16'h1234;
        do_op(2'b10, 1, 16'h0000);
        chk("R6", "preset set mask", 32'(set_seen), 32'h0000EDCB);
        chk("R6", "array ones", 32'(mem[1]), 32'h0000FFFF);
        chk("R9", "preset count", 32'(r_cnt), 32'd1);
        do_op(2'b01, 1, 16'h0F0F);
        chk("R6", "read cycles", 32'(rd_cyc), 32'd2);
        chk("R6", "no set", 32'(set_cyc), 32'd0);
        chk("R6", "rst mask", 32'(rst_seen), 32'h0000F0F0);
        chk("R6", "array", 32'(mem[1]), 32'h00000F0F);
        chk("R9", "count", 32'(r_cnt), 32'd2);
    endtask

    task automatic t_retry_ok();
        drop_set = 1'b1;
        do_op(2'b01, 2, 16'h00FF);
        chk("R7", "resp_err", 32'(r_err), 32'd0);
        chk("R7", "read cycles", 32'(rd_cyc), 32'd8);
        chk("R7", "set cycles", 32'(set_cyc), 32'd40);
        chk("R7", "array", 32'(mem[2]), 32'h000000FF);
        chk("R9", "count two passes", 32'(r_cnt), 32'd2);
        chk("R8", "no error flag", 32'(err_flag), 32'd0);
    endtask

    task automatic t_retry_fail();
        stuck0[3] = 16'h0001;
        do_op(2'b01, 3, 16'h0001);
        chk("R8", "resp_err", 32'(r_err), 32'd1);
        chk("R8", "err_flag", 32'(err_flag), 32'd1);
        chk("R8", "err_addr", 32'(err_addr), 32'd3);
        chk("R7", "read cycles", 32'(rd_cyc), 32'd8);
        repeat (3) @(negedge clk);
        chk("R8", "flag sticky", 32'(err_flag), 32'd1);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        chk("R8", "flag cleared", 32'(err_flag), 32'd0);
        stuck0[3] = '0;
    endtask

    task automatic t_wear();
        wear_limit = 4'd5;
        for (int i = 0; i < 4; i++) do_op(2'b01, 4, (i % 2 == 0) ? 16'hAAAA : 16'h5555);
        chk("R10", "alert below limit", 32'(wear_alert), 32'd0);
        do_op(2'b01, 4, 16'hAAAA);
        chk("R10", "alert at limit", 32'(wear_alert), 32'd1);
        chk("R9", "count", 32'(r_cnt), 32'd5);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        chk("R10", "alert cleared", 32'(wear_alert), 32'd0);
        for (int i = 0; i < 10; i++) do_op(2'b01, 4, (i % 2 == 0) ? 16'h5555 : 16'hAAAA);
        chk("R11", "count at max", 32'(r_cnt), 32'd15);
        do_op(2'b01, 4, 16'h5555);
        chk("R11", "count saturated", 32'(r_cnt), 32'd15);
        chk("R3", "array after wear", 32'(mem[4]), 32'h00005555);
    endtask

    // Global watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            mem[i] = '0;
            stuck0[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_fresh();
        t_write_both();
        t_write_same();
        t_read();
        t_zero_only();
        t_preset();
        t_retry_ok();
        t_retry_fail();
        t_wear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule